// File: doc/BRIEF.md
# Staged Memory Access Interface

This block connects a processor datapath to a word-addressed synchronous memory. All traffic goes through two staging registers, one holding the address and one holding the data word. Nothing in the datapath reaches the memory directly. The processor stages an address, and stages a data word as well for a store. It then raises a read or write request. The block sequences the memory strobes and signals completion with a one-cycle done pulse.

A read stages the address and strobes the memory for one cycle. The memory answers one cycle later, and the block captures that word into the data register. A write stages both the address and the data word, then pulses the memory write enable for one cycle. That stores the data register at the location held in the address register. While a transfer is in flight the block reports busy. It ignores new requests and processor loads to either register, so the staged values cannot change under the memory.

Top module: `mem_stage_if`

## Requirements
- R1: A synchronous active-high reset clears the address and data registers and deasserts busy, done, mem_re and mem_we, including when reset arrives in the middle of a transfer.
- R2: While idle, ld_addr high at a clock edge copies addr_in into the address register, and the value appears on addr_q and mem_addr after that edge.
- R3: While idle, ld_data high at a clock edge copies data_in into the data register, and the value appears on data_q and mem_wdata after that edge.
- R4: When rd_req is accepted at edge k, mem_re is high for exactly the cycle between edges k and k+1. The memory word at that address appears on data_q after edge k+2, together with done.
- R5: When wr_req is accepted at edge k, mem_we is high for exactly the cycle between edges k and k+1, with mem_addr equal to addr_q and mem_wdata equal to data_q. done is high between edges k+1 and k+2.
- R6: busy is high from an accepted request until the edge that raises done: two cycles for a read and one cycle for a write. It is low in the done cycle, so a new request is accepted there.
- R7: rd_req or wr_req sampled while busy is ignored: no further mem_re, mem_we or done follows.
- R8: ld_addr and ld_data sampled while busy are ignored, so addr_q and data_q keep their values. The one exception is the read capture of R4.
- R9: If rd_req and wr_req are both high in an idle cycle, the write is performed and the read is dropped.
- R10: A register load and a request in the same idle cycle are both taken, and the transfer uses the newly loaded values.
- R11: mem_re and mem_we are never high together, and done never stays high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_addr | input | 1 | Load the address register from addr_in |
| addr_in | input | ADDR_W | Address from the datapath |
| ld_data | input | 1 | Load the data register from data_in |
| data_in | input | DATA_W | Data word from the datapath |
| rd_req | input | 1 | Request a memory read |
| wr_req | input | 1 | Request a memory write |
| mem_rdata | input | DATA_W | Word returned by memory one cycle after mem_re |
| addr_q | output | ADDR_W | Address register contents |
| data_q | output | DATA_W | Data register contents |
| mem_addr | output | ADDR_W | Memory address, driven from the address register |
| mem_wdata | output | DATA_W | Memory write data, driven from the data register |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write enable |
| busy | output | 1 | A transfer is in flight |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two functions can fall in the same cycle: a processor load of a staging register, and the start or progress of a transfer. The bench raises a load together with a request in one idle cycle. It expects the memory strobe cycle to carry the newly loaded address and word. The bench also drives loads and requests with junk values during every busy cycle of both a read and a write. It then judges at the ports that the strobes, done and the registers were untouched, except for the read capture of the memory word.

// File: rtl/mem_stage_pkg.sv
package mem_stage_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_RD_WAIT = 2'd1,
    ST_RD_CAP  = 2'd2,
    ST_WR      = 2'd3
  } xfer_state_t;
endpackage

// File: rtl/stage_reg.sv
module stage_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/xfer_seq.sv
module xfer_seq
  import mem_stage_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic rd_req,
  input  logic wr_req,
  output logic idle,
  output logic capture,
  output logic mem_re,
  output logic mem_we,
  output logic busy,
  output logic done
);
  xfer_state_t st, nxt;

  always_comb begin
    nxt = st;
    unique case (st)
      ST_IDLE: begin
        if (wr_req)      nxt = ST_WR;
        else if (rd_req) nxt = ST_RD_WAIT;
      end
      ST_RD_WAIT: nxt = ST_RD_CAP;
      ST_RD_CAP:  nxt = ST_IDLE;
      ST_WR:      nxt = ST_IDLE;
      default:    nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      mem_re <= 1'b0;
      mem_we <= 1'b0;
      busy   <= 1'b0;
      done   <= 1'b0;
    end else begin
      st     <= nxt;
      mem_re <= (nxt == ST_RD_WAIT);
      mem_we <= (nxt == ST_WR);
      busy   <= (nxt != ST_IDLE);
      done   <= (st == ST_RD_CAP) || (st == ST_WR);
    end
  end

  assign idle    = (st == ST_IDLE);
  assign capture = (st == ST_RD_CAP);

  AST_WE_SINGLE:   assert property (@(posedge clk) disable iff (rst) mem_we |=> !mem_we);                  // R5
  AST_WR_DONE:     assert property (@(posedge clk) disable iff (rst) mem_we |=> done);                     // R5
  AST_RD_DONE:     assert property (@(posedge clk) disable iff (rst) mem_re |=> ##1 done);                 // R4
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst) !(mem_re && mem_we));                 // R11
  AST_DONE_PULSE:  assert property (@(posedge clk) disable iff (rst) done |=> !done);                      // R11
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (rst) busy |=> (!mem_re && !mem_we));       // R7
  AST_WR_WINS:     assert property (@(posedge clk) disable iff (rst)
                     (idle && wr_req && rd_req) |=> (mem_we && !mem_re));                                  // R9
endmodule

// File: rtl/mem_stage_if.sv
module mem_stage_if #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_addr,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              ld_data,
  input  logic [DATA_W-1:0] data_in,
  input  logic              rd_req,
  input  logic              wr_req,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] data_q,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_re,
  output logic              mem_we,
  output logic              busy,
  output logic              done
);
  logic              idle;
  logic              capture;
  logic              addr_en;
  logic              data_en;
  logic [DATA_W-1:0] data_d;

  xfer_seq u_seq (
    .clk     (clk),
    .rst     (rst),
    .rd_req  (rd_req),
    .wr_req  (wr_req),
    .idle    (idle),
    .capture (capture),
    .mem_re  (mem_re),
    .mem_we  (mem_we),
    .busy    (busy),
    .done    (done)
  );

  assign addr_en = ld_addr && idle;
  assign data_en = (ld_data && idle) || capture;
  assign data_d  = capture ? mem_rdata : data_in;

  stage_reg #(.W(ADDR_W)) u_addr_reg (
    .clk (clk),
    .rst (rst),
    .en  (addr_en),
    .d   (addr_in),
    .q   (addr_q)
  );

  stage_reg #(.W(DATA_W)) u_data_reg (
    .clk (clk),
    .rst (rst),
    .en  (data_en),
    .d   (data_d),
    .q   (data_q)
  );

  assign mem_addr  = addr_q;
  assign mem_wdata = data_q;

  AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (rst) busy |=> $stable(addr_q));                 // R8
  AST_DATA_FROZEN: assert property (@(posedge clk) disable iff (rst) (busy && !capture) |=> $stable(data_q));  // R8
  AST_WR_SOURCE:   assert property (@(posedge clk) disable iff (rst) mem_we |-> (mem_wdata == data_q));        // R5
endmodule

// File: tb/mem_stage_if_test.sv
`timescale 1ns/1ps
module mem_stage_if_test;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int MEM_LOG2 = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ld_addr = 1'b0, ld_data = 1'b0, rd_req = 1'b0, wr_req = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [DW-1:0] data_in = '0;
  logic [DW-1:0] mem_rdata;
  logic [AW-1:0] addr_q, mem_addr;
  logic [DW-1:0] data_q, mem_wdata;
  logic          mem_re, mem_we, busy, done;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  mem_stage_if #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst(rst), .ld_addr(ld_addr), .addr_in(addr_in),
    .ld_data(ld_data), .data_in(data_in), .rd_req(rd_req), .wr_req(wr_req),
    .mem_rdata(mem_rdata), .addr_q(addr_q), .data_q(data_q),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_re(mem_re),
    .mem_we(mem_we), .busy(busy), .done(done)
  );

  logic [DW-1:0] mem [0:(1<<MEM_LOG2)-1];
  initial begin
    for (int i = 0; i < (1<<MEM_LOG2); i++) mem[i] = '0;
    mem_rdata = '0;
  end
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[MEM_LOG2-1:0]] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_addr[MEM_LOG2-1:0]];
  end

  function automatic logic [DW-1:0] pattern(input int a);
    logic [DW-1:0] v;
    v = DW'(a * 40503 + 7) ^ DW'(a << 3);
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    ld_addr = 1; addr_in = a; ld_data = 1; data_in = d;
    cyc();
    ld_addr = 0; ld_data = 0;
    chk(addr_q == a, "R2", "addr_q", 32'(addr_q), 32'(a));
    chk(data_q == d, "R3", "data_q", 32'(data_q), 32'(d));
    wr_req = 1;
    cyc();
    wr_req = 0;
    chk(mem_we && !mem_re && busy && !done, "R5", "we/re/busy/done",
        {mem_we, mem_re, busy, done}, 32'b1010);
    chk(mem_addr == a && mem_wdata == d, "R5", "mem_addr/wdata",
        {mem_addr, mem_wdata}, {a, d});
    cyc();
    chk(!mem_we && done && !busy, "R6", "we/done/busy after write",
        {mem_we, done, busy}, 32'b010);
    cyc();
    chk(!done, "R11", "done pulse width", 32'(done), 0);
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] exp);
    ld_addr = 1; addr_in = a;
    cyc();
    ld_addr = 0;
    rd_req = 1;
    cyc();
    rd_req = 0;
    chk(mem_re && !mem_we && busy && !done, "R4", "re/we/busy/done cycle1",
        {mem_re, mem_we, busy, done}, 32'b1010);
    cyc();
    chk(!mem_re && busy && !done, "R6", "re/busy/done cycle2",
        {mem_re, busy, done}, 32'b010);
    cyc();
    chk(done && !busy, "R4", "done/busy cycle3", {done, busy}, 32'b10);
    chk(data_q == exp, "R4", "read data", 32'(data_q), 32'(exp));
    cyc();
    chk(!done, "R11", "done pulse width", 32'(done), 0);
  endtask

  initial begin
    cyc(); cyc();
    rst = 0;
    cyc();
    chk(addr_q == 0 && data_q == 0, "R1", "regs after reset", {addr_q, data_q}, 0);
    chk(!busy && !done && !mem_re && !mem_we, "R1", "flags after reset",
        {busy, done, mem_re, mem_we}, 0);

    for (int a = 0; a < 64; a++) do_write(AW'(a * 3), pattern(a));
    for (int a = 63; a >= 0; a--) do_read(AW'(a * 3), pattern(a));
    do_read(AW'(200), '0);

    // R7 R8: requests and loads while a write is busy
    ld_addr = 1; addr_in = 16'h0011; ld_data = 1; data_in = 16'hBEEF;
    cyc();
    ld_addr = 0; ld_data = 0;
    wr_req = 1;
    cyc();
    rd_req = 1; ld_addr = 1; addr_in = 16'h0022; ld_data = 1; data_in = 16'h1111;
    cyc();
    wr_req = 0; rd_req = 0; ld_addr = 0; ld_data = 0;
    chk(!mem_we && !mem_re && done, "R7", "no strobe for busy request",
        {mem_we, mem_re, done}, 32'b001);
    chk(addr_q == 16'h0011 && data_q == 16'hBEEF, "R8", "regs kept during write",
        {addr_q, data_q}, {16'h0011, 16'hBEEF});
    cyc();
    chk(!done && !busy && !mem_we && !mem_re, "R7", "no second transfer",
        {done, busy, mem_we, mem_re}, 0);
    do_read(16'h0011, 16'hBEEF);

    // R7 R8: loads and requests during both busy read cycles
    ld_addr = 1; addr_in = 16'h0011;
    cyc();
    ld_addr = 0; rd_req = 1;
    cyc();
    ld_addr = 1; addr_in = 16'h0033; ld_data = 1; data_in = 16'h5555; wr_req = 1;
    cyc();
    chk(!mem_we && !mem_re, "R7", "no strobe in read cycle2", {mem_we, mem_re}, 0);
    chk(addr_q == 16'h0011, "R8", "addr kept during read", 32'(addr_q), 32'h0011);
    cyc();
    ld_addr = 0; ld_data = 0; wr_req = 0; rd_req = 0;
    chk(data_q == 16'hBEEF && done, "R8", "capture beats busy load",
        {data_q, 15'd0, done}, {16'hBEEF, 16'd1});
    cyc();
    chk(!mem_we && !mem_re && !busy, "R7", "busy requests dropped",
        {mem_we, mem_re, busy}, 0);

    // R9: both requests together
    ld_addr = 1; addr_in = 16'h0044; ld_data = 1; data_in = 16'hA5A5;
    cyc();
    ld_addr = 0; ld_data = 0; wr_req = 1; rd_req = 1;
    cyc();
    wr_req = 0; rd_req = 0;
    chk(mem_we && !mem_re, "R9", "write wins", {mem_we, mem_re}, 32'b10);
    cyc(); cyc();
    do_read(16'h0044, 16'hA5A5);

    // R10: load and request in the same cycle
    ld_addr = 1; addr_in = 16'h0055; ld_data = 1; data_in = 16'h7E57; wr_req = 1;
    cyc();
    ld_addr = 0; ld_data = 0; wr_req = 0;
    chk(mem_we && mem_addr == 16'h0055 && mem_wdata == 16'h7E57, "R10",
        "write uses new values", {mem_addr, mem_wdata}, {16'h0055, 16'h7E57});
    cyc(); cyc();
    ld_addr = 1; addr_in = 16'h0055; rd_req = 1;
    cyc();
    ld_addr = 0; rd_req = 0;
    chk(mem_re && mem_addr == 16'h0055, "R10", "read uses new address",
        32'(mem_addr), 32'h0055);
    cyc(); cyc();
    chk(data_q == 16'h7E57, "R10", "read data", 32'(data_q), 32'h7E57);
    cyc();

    // R1: reset in the middle of a read
    rd_req = 1;
    cyc();
    rd_req = 0;
    rst = 1;
    cyc();
    rst = 0;
    chk(!busy && !mem_re && !mem_we && !done && addr_q == 0 && data_q == 0, "R1",
        "reset mid transfer", {busy, mem_re, mem_we, done, addr_q, data_q}, 0);
    cyc(); cyc();
    chk(!done && !busy, "R1", "idle after reset", {done, busy}, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule